// File: doc/BRIEF.md
# Bus-to-SRAM Block Transfer Engine

This block streams bytes between an instrument-bus byte port and a 32 KiB on-board SRAM, one block at a time. A host programs it through a small byte-wide register file. The host loads a block length, picks a direction, enables the engine and then restarts the stream. The bus handshake, the host bridge and the SRAM array sit outside the block and are seen only as simple ports.

The host loads the transfer counter with the negative of the length. The counter counts up by one for each byte moved. In the listen direction each received byte is written to SRAM. In the talk direction bytes are fetched from SRAM and offered on the bus port. The SRAM address starts at zero after every counter load.

The stream stops in two cases: the counter reaches zero, or, in the listen direction, a byte arrives flagged as the last of a message. Either case records a maskable event and can raise the host interrupt. A stopped stream stays halted until the host restarts it. A restart does not reload the counter.

Top module: `gsm_top`

## Requirements
- R1: After reset the stream reads as halted (register 0x07 bit 0 = 1). Registers 0x04 and 0x1F read 0x00, and neither `host_irq` nor `tx_valid` is asserted.
- R2: The counter is 20 bits wide. Writing 0x0C loads bits 7:0, writing 0x0D loads bits 15:8, and writing 0x0E loads bits 19:16 from data bits 3:0. Reading 0x0C and 0x0D returns the live bits 7:0 and 15:8, and reading 0x0E returns bits 19:16 in data bits 3:0.
- R3: In register 0x1F, bit 6 enables the engine and bit 5 selects the direction (1 = listen, bus to SRAM). While the stream is halted no byte moves, even when enabled. Writing 1 to bit 0 of 0x07 clears the halt, and writing 0 there has no effect.
- R4: While running in the listen direction, each `rx_strobe` writes `rx_byte` to SRAM and advances the counter by one. The write address is the number of bytes moved since the last counter load, so the first byte after a load goes to address 0.
- R5: When a move brings the counter to zero, the stream halts, and bit 5 of 0x04 sets if enabled. Later strobes store nothing and leave the counter unchanged.
- R6: In the listen direction, a byte with `rx_end` high is stored and counted. The stream then halts and bit 4 of 0x04 sets if enabled. The counter still shows how many bytes were stored.
- R7: In the talk direction the engine issues an SRAM read and raises `tx_valid` two clock edges after the stream starts running. It holds `tx_byte` until `tx_take`, and each take advances the counter and the address. The next byte is valid two edges after the take.
- R8: Writing 1 to bit 4 or bit 5 of 0x04 clears that status bit. Writing 0 leaves it set.
- R9: Register 0x05 bits 4 and 5 gate whether the end and terminal-count events latch into 0x04. A gated-off event still halts the stream.
- R10: `host_irq` is high only when 0x01 bit 5 is set and at least one enabled source in 0x03 is active: bit 0 with `ctl_irq`, bit 4 with status bit 4, or bit 5 with status bit 5. In 0x04, bit 0 mirrors `ctl_irq` and bit 1 mirrors `host_irq`.
- R11: A restart after an end-halt continues from the same counter value and SRAM address, without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` (combinational) |
| rx_strobe | input | 1 | A received bus byte is present this cycle |
| rx_byte | input | 8 | Received bus byte |
| rx_end | input | 1 | Received byte is the last of a message |
| tx_valid | output | 1 | `tx_byte` holds a byte for the bus |
| tx_byte | output | 8 | Byte to send on the bus |
| tx_take | input | 1 | Bus port consumes `tx_byte` |
| ctl_irq | input | 1 | Interrupt request from the bus controller |
| host_irq | output | 1 | Interrupt to the host |
| sram_we | output | 1 | SRAM write enable |
| sram_re | output | 1 | SRAM read enable (data returns one cycle later) |
| sram_addr | output | 15 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |

## Verification
Most wrong internal states surface at once on the host read port. A counter that drifts, an address that fails to restart at zero, or a lost halt shows up in the next read of 0x0C, 0x07 or 0x04, or as a misplaced byte in the SRAM model on the very edge of the move. Talk-side faults appear within two edges: `tx_valid` rises a cycle early or late, or carries the byte from the wrong address. Status bits are checked both for latching and for clearing, so an inverted mask or a lost write-one-to-clear appears on the following read.

// File: rtl/gsm_pkg.sv
package gsm_pkg;

    localparam int CNT_W = 20;

    localparam logic [4:0] REG_MODE   = 5'h01;
    localparam logic [4:0] REG_IRQEN  = 5'h03;
    localparam logic [4:0] REG_EVST   = 5'h04;
    localparam logic [4:0] REG_EVEN   = 5'h05;
    localparam logic [4:0] REG_STREAM = 5'h07;
    localparam logic [4:0] REG_CLO    = 5'h0C;
    localparam logic [4:0] REG_CMID   = 5'h0D;
    localparam logic [4:0] REG_CHI    = 5'h0E;
    localparam logic [4:0] REG_ACC    = 5'h1F;

    localparam int B_ACC_EN   = 6;
    localparam int B_ACC_RX   = 5;
    localparam int B_EV_BE    = 4;
    localparam int B_EV_TC    = 5;
    localparam int B_CTL      = 0;
    localparam int B_MODE_IRQ = 5;
    localparam int B_RESTART  = 0;

    // control handed from the register file to the engine
    typedef struct packed {
        logic       en;
        logic       dir_rx;
        logic       restart;
        logic [2:0] ld;       // {hi, mid, lo} counter byte loads
        logic [7:0] ld_data;
    } eng_ctl_t;

    // one-cycle stop events raised by the engine
    typedef struct packed {
        logic tc;
        logic be;
    } eng_evt_t;

endpackage

// File: rtl/gsm_engine.sv
module gsm_engine
    import gsm_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  eng_ctl_t          ctl,
    input  logic              rx_strobe,
    input  logic [7:0]        rx_byte,
    input  logic              rx_end,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_take,
    output logic              sram_we,
    output logic              sram_re,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_wdata,
    input  logic [7:0]        sram_rdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              halted,
    output eng_evt_t          evt
);

    logic [ADDR_W-1:0] addr;
    logic              pend;
    logic              run, run_tx, mv_rx, mv_tx, mv, fetch;
    logic [CNT_W-1:0]  cnt_nx;

    always_comb begin
        run    = ctl.en & ~halted;
        run_tx = run & ~ctl.dir_rx;
        mv_rx  = run & ctl.dir_rx & rx_strobe;
        mv_tx  = run_tx & tx_valid & tx_take;
        mv     = mv_rx | mv_tx;
        fetch  = run_tx & ~tx_valid & ~pend;
        cnt_nx = cnt + CNT_W'(1);
        evt.tc = mv & (cnt_nx == '0);
        evt.be = mv_rx & rx_end;
    end

    assign sram_we    = mv_rx;
    assign sram_re    = fetch;
    assign sram_addr  = addr;
    assign sram_wdata = rx_byte;

    // counter and block address
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            addr <= '0;
        end else if (ctl.ld != 3'b000) begin
            if (ctl.ld[0]) cnt[7:0]   <= ctl.ld_data;
            if (ctl.ld[1]) cnt[15:8]  <= ctl.ld_data;
            if (ctl.ld[2]) cnt[19:16] <= ctl.ld_data[3:0];
            addr <= '0;
        end else if (mv) begin
            cnt  <= cnt_nx;
            addr <= addr + ADDR_W'(1);
        end
    end

    // halt latch: a stop event wins over a same-cycle restart
    always_ff @(posedge clk) begin
        if (rst)                   halted <= 1'b1;
        else if (evt.tc | evt.be)  halted <= 1'b1;
        else if (ctl.restart)      halted <= 1'b0;
    end

    // talk-side fetch with one cycle of SRAM latency
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            pend     <= 1'b0;
        end else if (!run_tx) begin
            tx_valid <= 1'b0;
            pend     <= 1'b0;
        end else begin
            pend <= fetch;
            if (pend) begin
                tx_valid <= 1'b1;
                tx_byte  <= sram_rdata;
            end else if (mv_tx) begin
                tx_valid <= 1'b0;
            end
        end
    end

    assert_halt_on_tc_R5: assert property (@(posedge clk) disable iff (rst)
        evt.tc |=> halted);

    assert_halt_freezes_R3: assert property (@(posedge clk) disable iff (rst)
        (halted && ctl.ld == 3'b000) |=> $stable(cnt));

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(sram_re, 2));

endmodule

// File: rtl/gsm_irq.sv
module gsm_irq (
    input  logic       mode_irq,
    input  logic [2:0] irq_en,    // {terminal count, buffer end, controller}
    input  logic       ctl_irq,
    input  logic       st_be,
    input  logic       st_tc,
    output logic       host_irq
);

    logic [2:0] src;

    always_comb begin
        src      = {st_tc, st_be, ctl_irq} & irq_en;
        host_irq = mode_irq & (|src);
    end

endmodule

// File: rtl/gsm_regs.sv
module gsm_regs
    import gsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [4:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output eng_ctl_t         ctl,
    input  eng_evt_t         evt,
    input  logic [CNT_W-1:0] cnt,
    input  logic             halted,
    input  logic             ctl_irq,
    input  logic             host_irq,
    output logic             mode_irq,
    output logic [2:0]       irq_en,
    output logic             st_be,
    output logic             st_tc
);

    logic       acc_en, acc_rx, ee_be, ee_tc;
    logic       wr_evst;

    assign wr_evst = host_wr && (host_addr == REG_EVST);

    always_comb begin
        ctl.en      = acc_en;
        ctl.dir_rx  = acc_rx;
        ctl.restart = host_wr && (host_addr == REG_STREAM) && host_wdata[B_RESTART];
        ctl.ld      = {3{host_wr}} & {host_addr == REG_CHI, host_addr == REG_CMID,
                                      host_addr == REG_CLO};
        ctl.ld_data = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_en   <= 1'b0;
            acc_rx   <= 1'b0;
            ee_be    <= 1'b0;
            ee_tc    <= 1'b0;
            mode_irq <= 1'b0;
            irq_en   <= '0;
        end else if (host_wr) begin
            case (host_addr)
                REG_ACC: begin
                    acc_en <= host_wdata[B_ACC_EN];
                    acc_rx <= host_wdata[B_ACC_RX];
                end
                REG_EVEN: begin
                    ee_be <= host_wdata[B_EV_BE];
                    ee_tc <= host_wdata[B_EV_TC];
                end
                REG_MODE:  mode_irq <= host_wdata[B_MODE_IRQ];
                REG_IRQEN: irq_en   <= {host_wdata[B_EV_TC], host_wdata[B_EV_BE],
                                        host_wdata[B_CTL]};
                default: ;
            endcase
        end
    end

    // status: write-one-to-clear, a new event wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            st_be <= 1'b0;
            st_tc <= 1'b0;
        end else begin
            st_be <= (st_be & ~(wr_evst & host_wdata[B_EV_BE])) | (evt.be & ee_be);
            st_tc <= (st_tc & ~(wr_evst & host_wdata[B_EV_TC])) | (evt.tc & ee_tc);
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        case (host_addr)
            REG_MODE:   host_rdata[B_MODE_IRQ] = mode_irq;
            REG_IRQEN:  host_rdata = {2'b00, irq_en[2], irq_en[1], 3'b000, irq_en[0]};
            REG_EVST:   host_rdata = {2'b00, st_tc, st_be, 2'b00, host_irq, ctl_irq};
            REG_EVEN:   host_rdata = {2'b00, ee_tc, ee_be, 4'b0000};
            REG_STREAM: host_rdata = {7'b0, halted};
            REG_CLO:    host_rdata = cnt[7:0];
            REG_CMID:   host_rdata = cnt[15:8];
            REG_CHI:    host_rdata = {4'b0000, cnt[19:16]};
            REG_ACC:    host_rdata = {1'b0, acc_en, acc_rx, 5'b00000};
            default:    host_rdata = 8'h00;
        endcase
    end

    assert_tc_latch_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(st_tc) |-> $past(evt.tc && ee_tc));

    assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_evst && host_wdata[B_EV_TC] && !evt.tc) |=> !st_tc);

endmodule

// File: rtl/gsm_top.sv
module gsm_top
    import gsm_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [4:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              rx_strobe,
    input  logic [7:0]        rx_byte,
    input  logic              rx_end,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_take,
    input  logic              ctl_irq,
    output logic              host_irq,
    output logic              sram_we,
    output logic              sram_re,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_wdata,
    input  logic [7:0]        sram_rdata
);

    eng_ctl_t         ctl;
    eng_evt_t         evt;
    logic [CNT_W-1:0] cnt;
    logic             halted, mode_irq, st_be, st_tc;
    logic [2:0]       irq_en;

    gsm_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ctl        (ctl),
        .evt        (evt),
        .cnt        (cnt),
        .halted     (halted),
        .ctl_irq    (ctl_irq),
        .host_irq   (host_irq),
        .mode_irq   (mode_irq),
        .irq_en     (irq_en),
        .st_be      (st_be),
        .st_tc      (st_tc)
    );

    gsm_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .rx_strobe  (rx_strobe),
        .rx_byte    (rx_byte),
        .rx_end     (rx_end),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .tx_take    (tx_take),
        .sram_we    (sram_we),
        .sram_re    (sram_re),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata),
        .cnt        (cnt),
        .halted     (halted),
        .evt        (evt)
    );

    gsm_irq u_irq (
        .mode_irq (mode_irq),
        .irq_en   (irq_en),
        .ctl_irq  (ctl_irq),
        .st_be    (st_be),
        .st_tc    (st_tc),
        .host_irq (host_irq)
    );

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (ctl_irq || st_be || st_tc));

endmodule

// File: tb/tb_gsm_top.sv
module tb_gsm_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr;
    logic [4:0]  host_addr;
    logic [7:0]  host_wdata;
    logic [7:0]  host_rdata;
    logic        rx_strobe;
    logic [7:0]  rx_byte;
    logic        rx_end;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_take;
    logic        ctl_irq;
    logic        host_irq;
    logic        sram_we;
    logic        sram_re;
    logic [14:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata;

    logic [7:0]  mem [256];
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gsm_top dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_strobe(rx_strobe),
        .rx_byte(rx_byte), .rx_end(rx_end), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_take(tx_take), .ctl_irq(ctl_irq), .host_irq(host_irq), .sram_we(sram_we),
        .sram_re(sram_re), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata)
    );

    // SRAM model: one cycle read latency
    always @(posedge clk) begin
        if (sram_we) mem[sram_addr[7:0]] <= sram_wdata;
        if (sram_re) sram_rdata <= mem[sram_addr[7:0]];
    end

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic e);
        @(negedge clk);
        rx_strobe = 1'b1; rx_byte = b; rx_end = e;
        @(negedge clk);
        rx_strobe = 1'b0; rx_end = 1'b0;
    endtask

    task automatic load_len(input int n);
        logic [19:0] c;
        c = 20'(-n);
        wr(5'h0C, c[7:0]);
        wr(5'h0D, c[15:8]);
        wr(5'h0E, {4'hF, c[19:16]});
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(5'h07, d); check("R1", "halted after reset", d, 8'h01);
        rd(5'h04, d); check("R1", "status after reset", d, 8'h00);
        rd(5'h1F, d); check("R1", "access after reset", d, 8'h00);
        check("R1", "irq after reset", host_irq, 1'b0);
        check("R1", "tx_valid after reset", tx_valid, 1'b0);
    endtask

    task automatic t_load;
        logic [7:0] d;
        load_len(5);
        rd(5'h0C, d); check("R2", "counter lo", d, 8'hFB);
        rd(5'h0D, d); check("R2", "counter mid", d, 8'hFF);
        rd(5'h0E, d); check("R2", "counter hi masked", d, 8'h0F);
    endtask

    task automatic t_halted_hold;
        logic [7:0] d;
        mem[0] = 8'hEE;
        wr(5'h1F, 8'h60);
        rd(5'h1F, d); check("R3", "access readback", d, 8'h60);
        rx_send(8'h5A, 1'b0);
        rd(5'h0C, d); check("R3", "no count while halted", d, 8'hFB);
        check("R3", "no store while halted", mem[0], 8'hEE);
        wr(5'h07, 8'h00);
        rd(5'h07, d); check("R3", "zero write keeps halt", d, 8'h01);
        wr(5'h07, 8'h01);
        rd(5'h07, d); check("R3", "restart clears halt", d, 8'h00);
    endtask

    task automatic t_listen_tc;
        logic [7:0] d;
        mem[5] = 8'hEE;
        wr(5'h05, 8'h30); wr(5'h03, 8'h30); wr(5'h01, 8'h20);
        for (int i = 0; i < 3; i++) rx_send(8'hA0 + 8'(i), 1'b0);
        rd(5'h0C, d); check("R4", "live count after 3", d, 8'hFE);
        rd(5'h04, d); check("R5", "no tc yet", d, 8'h00);
        for (int i = 3; i < 5; i++) rx_send(8'hA0 + 8'(i), 1'b0);
        for (int i = 0; i < 5; i++) check("R4", "stored byte", mem[i], 8'hA0 + 8'(i));
        rd(5'h04, d); check("R5", "tc status", d, 8'h22);
        rd(5'h07, d); check("R5", "halted at tc", d, 8'h01);
        check("R10", "irq on tc", host_irq, 1'b1);
        rx_send(8'h77, 1'b0);
        check("R5", "strobe after tc ignored", mem[5], 8'hEE);
        rd(5'h0C, d); check("R5", "count frozen at zero", d, 8'h00);
    endtask

    task automatic t_w1c;
        logic [7:0] d;
        wr(5'h04, 8'h00);
        rd(5'h04, d); check("R8", "zero write keeps status", d, 8'h22);
        wr(5'h04, 8'h20);
        rd(5'h04, d); check("R8", "one write clears", d, 8'h00);
        check("R8", "irq drops after clear", host_irq, 1'b0);
    endtask

    task automatic t_listen_end;
        logic [7:0] d;
        load_len(8);
        wr(5'h07, 8'h01);
        rx_send(8'hB0, 1'b0); rx_send(8'hB1, 1'b0); rx_send(8'hB2, 1'b1);
        rd(5'h04, d); check("R6", "end status", d, 8'h12);
        rd(5'h07, d); check("R6", "halted at end", d, 8'h01);
        rd(5'h0C, d); check("R6", "count after end", d, 8'hFB);
        check("R6", "end byte stored", mem[2], 8'hB2);
        wr(5'h04, 8'h10);
        wr(5'h07, 8'h01);
        rx_send(8'hB3, 1'b0); rx_send(8'hB4, 1'b0);
        check("R11", "resume address 3", mem[3], 8'hB3);
        check("R11", "resume address 4", mem[4], 8'hB4);
        rd(5'h0C, d); check("R11", "count continues", d, 8'hFD);
    endtask

    task automatic t_gating;
        logic [7:0] d;
        wr(5'h05, 8'h00);
        load_len(2);
        rx_send(8'hC0, 1'b0); rx_send(8'hC1, 1'b0);
        check("R4", "address zero after load", mem[0], 8'hC0);
        rd(5'h07, d); check("R9", "gated tc still halts", d, 8'h01);
        rd(5'h04, d); check("R9", "gated tc not latched", d, 8'h00);
        check("R9", "no irq when gated", host_irq, 1'b0);
    endtask

    task automatic t_talk;
        logic [7:0] d;
        mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'h33;
        wr(5'h05, 8'h30);
        wr(5'h1F, 8'h40);
        load_len(3);
        wr(5'h07, 8'h01);
        for (int i = 0; i < 3; i++) begin
            check("R7", "not valid yet", tx_valid, 1'b0);
            @(negedge clk);
            check("R7", "not valid after one edge", tx_valid, 1'b0);
            @(negedge clk);
            check("R7", "valid after two edges", tx_valid, 1'b1);
            check("R7", "talk byte", tx_byte, 8'h11 * 8'(i + 1));
            @(negedge clk);
            check("R7", "byte held", tx_byte, 8'h11 * 8'(i + 1));
            tx_take = 1'b1;
            @(negedge clk);
            tx_take = 1'b0;
        end
        check("R7", "valid drops after take", tx_valid, 1'b0);
        rd(5'h04, d); check("R7", "talk tc status", d, 8'h22);
        @(negedge clk); @(negedge clk);
        check("R7", "no fetch after tc", tx_valid, 1'b0);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        wr(5'h04, 8'h30);
        wr(5'h03, 8'h01);
        @(negedge clk);
        ctl_irq = 1'b1;
        #1;
        check("R10", "controller irq", host_irq, 1'b1);
        rd(5'h04, d); check("R10", "mirror bits", d, 8'h03);
        wr(5'h01, 8'h00);
        check("R10", "mode gate off", host_irq, 1'b0);
        rd(5'h04, d); check("R10", "mirror with gate off", d, 8'h01);
        ctl_irq = 1'b0;
    endtask

    initial begin
        rst = 1'b1; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        rx_strobe = 1'b0; rx_byte = '0; rx_end = 1'b0; tx_take = 1'b0; ctl_irq = 1'b0;
        sram_rdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_load;
        t_halted_hold;
        t_listen_tc;
        t_w1c;
        t_listen_end;
        t_gating;
        t_talk;
        t_irq;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule